// File: doc/BRIEF.md
# Port C Single-Bit Command Unit

This block holds the 8-bit output latch of the third general-purpose port and a small set of interrupt-enable mask flip-flops. Each of them is changed by a one-byte command on a valid/ready stream. When the most significant bit of the command byte is 0, the byte is a single-bit command. Its bits 3 to 1 pick one of the eight latch positions, and bit 0 gives the new value. No read-modify-write is needed, and the other seven bits keep their values. A byte whose top bit is 1 is a mode word and belongs to the mode register. This unit accepts that byte and drops it.

Some latch positions double as the control for an interrupt-enable mask. The parameters `INTE_POS` and `INTE_GRP` list, for each mask, its bit position and its owning group (0 for group A, 1 for group B). When the owning group runs a handshake mode, a command aimed at that position writes the mask. With `MASK_AND_LATCH = 0` it writes the mask instead of the latch bit, and with `MASK_AND_LATCH = 1` it writes both. Group A runs a handshake mode when `grp_a_mode` is nonzero, and group B when `grp_b_mode` is 1. The mode register raises `mode_chg` for one cycle on each mode-set write, and that pulse clears every mask and the whole latch.

The command stream has no back-pressure: `cmd_ready` is high in every cycle out of reset. A byte transfers on any rising edge where `cmd_valid` and `cmd_ready` are both high. Its effect is visible on the outputs right after that edge. A producer may hold `cmd_valid` high for several cycles, and each such cycle counts as a separate command.

Top module: `pc_bitctl`

## Requirements
- R1: While `rst` is high, and after it falls, `pc_latch` is 8'h00 and every bit of `inte_mask` is 0, until the first accepted command.
- R2: An accepted byte with bit 7 = 0 and bit 0 = 1 sets the latch bit whose index is given by bits 3:1, with bit 1 as the least significant bit. The change shows after that clock edge.
- R3: An accepted byte with bit 7 = 0 and bit 0 = 0 clears the latch bit indexed by bits 3:1.
- R4: A single-bit command leaves the other seven latch bits unchanged, for all 16 combinations of bits 3:0.
- R5: Bits 6:4 of a single-bit command have no effect on the result.
- R6: An accepted byte with bit 7 = 1 changes neither `pc_latch` nor `inte_mask`.
- R7: In a cycle with `cmd_valid` low and `mode_chg` low, both outputs hold their values.
- R8: If the group that owns a mask runs a handshake mode, a command to the mask's position writes bit 0 of the command into the mask. With the default `MASK_AND_LATCH = 0`, the latch bit at that position is left unchanged.
- R9: If the owning group is in basic mode, a command to a mask position writes the latch bit and leaves the mask unchanged.
- R10: A `mode_chg` pulse clears `pc_latch` and all of `inte_mask` at the next edge. This takes priority over a command accepted in the same cycle.
- R11: `cmd_ready` is 0 during reset and 1 in every cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command byte present |
| cmd_ready | output | 1 | Unit can take a command byte |
| cmd_data | input | 8 | Command byte |
| mode_chg | input | 1 | One-cycle pulse from the mode register on a mode-set write |
| grp_a_mode | input | 2 | Current group A mode (0 basic, 1 or 2/3 handshake) |
| grp_b_mode | input | 1 | Current group B mode (0 basic, 1 handshake) |
| pc_latch | output | 8 | Port C output latch |
| inte_mask | output | NUM_INTE | Interrupt-enable mask flip-flops |

## Verification
The assertions assume the following about the inputs:
- `mode_chg` is a pulse that the mode register raises on its own schedule.
- The group mode inputs change only between commands, never in the same cycle as the command they should govern.
- `cmd_data` carries a known value whenever `cmd_valid` is high.

The stimulus drives every input on the falling clock edge, so each value is steady across the rising edge that samples it. It changes the group modes only in cycles with no command, and it raises `mode_chg` only in its own mode-change steps. One deliberate exception is a pulse sent together with a command, which exercises the priority rule.

// File: rtl/pc_bitctl_pkg.sv
package pc_bitctl_pkg;

  localparam int CMD_W   = 8;
  localparam int PORT_W  = 8;
  localparam int SEL_W   = 3;

  // decoded single-bit command
  typedef struct packed {
    logic             fire;  // accepted byte with top bit clear
    logic [SEL_W-1:0] sel;   // target bit index
    logic             val;   // value to write
  } bsr_cmd_t;

  // does the group owning a mask run a handshake mode
  function automatic logic grp_handshake(input logic grp_b, input logic [1:0] a_mode,
                                         input logic b_mode);
    return grp_b ? b_mode : (a_mode != 2'b00);
  endfunction

endpackage

// File: rtl/pc_bitctl_decode.sv
module pc_bitctl_decode
  import pc_bitctl_pkg::*;
(
  input  logic             cmd_valid,
  input  logic             cmd_ready,
  input  logic [CMD_W-1:0] cmd_data,
  output bsr_cmd_t         cmd
);
  // top bit 0 marks a single-bit command; bits 6:4 are never looked at
  always_comb begin
    cmd.fire = cmd_valid & cmd_ready & ~cmd_data[CMD_W-1];
    cmd.sel  = cmd_data[SEL_W:1];
    cmd.val  = cmd_data[0];
  end
endmodule

// File: rtl/pc_bitctl_route.sv
module pc_bitctl_route
  import pc_bitctl_pkg::*;
#(
  parameter int                      NUM_INTE       = 3,
  parameter logic [NUM_INTE*SEL_W-1:0] INTE_POS     = {3'd2, 3'd6, 3'd4},
  parameter logic [NUM_INTE-1:0]     INTE_GRP       = 3'b100,
  parameter bit                      MASK_AND_LATCH = 1'b0
) (
  input  bsr_cmd_t            cmd,
  input  logic [1:0]          grp_a_mode,
  input  logic                grp_b_mode,
  output logic                latch_we,
  output logic [NUM_INTE-1:0] mask_we
);
  logic [NUM_INTE-1:0] hit;

  for (genvar i = 0; i < NUM_INTE; i++) begin : g_hit
    localparam logic [SEL_W-1:0] POS = INTE_POS[i*SEL_W +: SEL_W];
    assign hit[i] = cmd.fire && (cmd.sel == POS) &&
                    grp_handshake(INTE_GRP[i], grp_a_mode, grp_b_mode);
  end

  assign mask_we = hit;

  if (MASK_AND_LATCH) begin : g_both
    assign latch_we = cmd.fire;
  end else begin : g_excl
    assign latch_we = cmd.fire && (hit == '0);
  end
endmodule

// File: rtl/pc_bitctl_latch.sv
module pc_bitctl_latch
  import pc_bitctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              we,
  input  logic [SEL_W-1:0]  idx,
  input  logic              val,
  output logic [PORT_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      q <= '0;
    end else if (we) begin
      q[idx] <= val;
    end
  end

  AST_BIT_WRITTEN: assert property (@(posedge clk) disable iff (rst)
    (we && !clr) |=> (q[$past(idx)] == $past(val))); // R2
  AST_ONE_BIT_ONLY: assert property (@(posedge clk) disable iff (rst)
    (we && !clr) |=> ($countones(q ^ $past(q)) <= 1)); // R4
endmodule

// File: rtl/pc_bitctl_mask.sv
module pc_bitctl_mask #(
  parameter int NUM_INTE = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic [NUM_INTE-1:0] we,
  input  logic                val,
  output logic [NUM_INTE-1:0] q
);
  for (genvar i = 0; i < NUM_INTE; i++) begin : g_ff
    always_ff @(posedge clk) begin
      if (rst || clr) q[i] <= 1'b0;
      else if (we[i]) q[i] <= val;
    end
  end

  AST_MASK_CLEARED: assert property (@(posedge clk) disable iff (rst)
    clr |=> (q == '0)); // R10
  AST_MASK_HELD: assert property (@(posedge clk) disable iff (rst)
    (!clr && we == '0) |=> $stable(q)); // R9
endmodule

// File: rtl/pc_bitctl.sv
module pc_bitctl
  import pc_bitctl_pkg::*;
#(
  parameter int                        NUM_INTE       = 3,
  parameter logic [NUM_INTE*SEL_W-1:0] INTE_POS       = {3'd2, 3'd6, 3'd4},
  parameter logic [NUM_INTE-1:0]       INTE_GRP       = 3'b100,
  parameter bit                        MASK_AND_LATCH = 1'b0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic [CMD_W-1:0]    cmd_data,
  input  logic                mode_chg,
  input  logic [1:0]          grp_a_mode,
  input  logic                grp_b_mode,
  output logic [PORT_W-1:0]   pc_latch,
  output logic [NUM_INTE-1:0] inte_mask
);
  bsr_cmd_t            cmd;
  logic                latch_we;
  logic [NUM_INTE-1:0] mask_we;

  assign cmd_ready = ~rst;

  pc_bitctl_decode u_dec (
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_data  (cmd_data),
    .cmd       (cmd)
  );

  pc_bitctl_route #(
    .NUM_INTE       (NUM_INTE),
    .INTE_POS       (INTE_POS),
    .INTE_GRP       (INTE_GRP),
    .MASK_AND_LATCH (MASK_AND_LATCH)
  ) u_route (
    .cmd        (cmd),
    .grp_a_mode (grp_a_mode),
    .grp_b_mode (grp_b_mode),
    .latch_we   (latch_we),
    .mask_we    (mask_we)
  );

  pc_bitctl_latch u_latch (
    .clk (clk),
    .rst (rst),
    .clr (mode_chg),
    .we  (latch_we),
    .idx (cmd.sel),
    .val (cmd.val),
    .q   (pc_latch)
  );

  pc_bitctl_mask #(.NUM_INTE(NUM_INTE)) u_mask (
    .clk (clk),
    .rst (rst),
    .clr (mode_chg),
    .we  (mask_we),
    .val (cmd.val),
    .q   (inte_mask)
  );

  AST_MODE_WORD_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_data[CMD_W-1] && !mode_chg) |=> ($stable(pc_latch) && $stable(inte_mask))); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!cmd_valid && !mode_chg) |=> ($stable(pc_latch) && $stable(inte_mask))); // R7
  AST_MODE_CLEARS_LATCH: assert property (@(posedge clk) disable iff (rst)
    mode_chg |=> (pc_latch == '0)); // R10
  AST_ALWAYS_READY: assert property (@(posedge clk) disable iff (rst)
    cmd_ready); // R11
endmodule

// File: tb/pc_bitctl_bench.sv
module pc_bitctl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 3;
  localparam logic [8:0] POS = {3'd2, 3'd6, 3'd4};
  localparam logic [2:0] GRP = 3'b100;

  logic clk = 0;
  logic rst = 1;
  logic cmd_valid = 0;
  logic [7:0] cmd_data = 0;
  logic mode_chg = 0;
  logic [1:0] grp_a_mode = 0;
  logic grp_b_mode = 0;
  logic cmd_ready;
  logic [7:0] pc_latch;
  logic [NI-1:0] inte_mask;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  logic [7:0] m_latch = 0;
  logic [NI-1:0] m_mask = 0;
  logic [7:0] q_l[$];
  logic [NI-1:0] q_m[$];
  string q_t[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pc_bitctl u_pc_bitctl (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .mode_chg(mode_chg), .grp_a_mode(grp_a_mode),
    .grp_b_mode(grp_b_mode), .pc_latch(pc_latch), .inte_mask(inte_mask)
  );

  function automatic logic hs(input int i);
    return GRP[i] ? grp_b_mode : (grp_a_mode != 0);
  endfunction

  // driver: applies one cycle of stimulus, updates the model, queues the expectation
  task automatic drive(input logic v, input logic [7:0] d, input logic mc, input string tag);
    @(negedge clk);
    cmd_valid = v; cmd_data = d; mode_chg = mc;
    if (mc) begin
      m_latch = 0; m_mask = 0;
    end else if (v && !d[7]) begin
      bit hit = 0;
      for (int i = 0; i < NI; i++)
        if (d[3:1] == POS[i*3 +: 3] && hs(i)) begin
          m_mask[i] = d[0]; hit = 1;
        end
      if (!hit) m_latch[d[3:1]] = d[0];
    end
    @(posedge clk);
    #1;
    cmd_valid = 0; mode_chg = 0;
    q_l.push_back(m_latch); q_m.push_back(m_mask); q_t.push_back(tag);
  endtask

  // monitor: compares the design against the queued expectation
  always @(negedge clk) begin
    if (q_t.size() > 0) begin
      logic [7:0] el;
      logic [NI-1:0] em;
      string t;
      el = q_l.pop_front(); em = q_m.pop_front(); t = q_t.pop_front();
      n_run++;
      if (pc_latch !== el || inte_mask !== em) begin
        n_fail++;
        $display("FAIL %s: latch=%h mask=%b expected latch=%h mask=%b",
                 t, pc_latch, inte_mask, el, em);
      end
    end
  end

  task automatic direct(input string tag, input logic ok, input string msg);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    direct("R11", cmd_ready === 1'b0, $sformatf("ready=%b expected 0 in reset", cmd_ready));
    direct("R1", pc_latch === 8'h00 && inte_mask === '0,
           $sformatf("latch=%h mask=%b expected 00/000", pc_latch, inte_mask));
    rst = 0;
    @(negedge clk);
    direct("R11", cmd_ready === 1'b1, $sformatf("ready=%b expected 1", cmd_ready));
    direct("R1", pc_latch === 8'h00 && inte_mask === '0,
           $sformatf("latch=%h mask=%b expected 00/000", pc_latch, inte_mask));

    // R2/R3/R4: basic mode, all 16 encodings, from two starting patterns
    for (int i = 0; i < 16; i++) drive(1, {4'b0000, i[3:0]}, 0, "R2_R3_R4_walk");
    for (int i = 0; i < 8; i++) drive(1, {4'b0000, i[2:0], 1'b1}, 0, "R2_fill");
    for (int i = 15; i >= 0; i--) drive(1, {4'b0000, i[3:0]}, 0, "R3_R4_walk_dn");
    // R5: junk in bits 6:4
    for (int i = 0; i < 16; i++) drive(1, {1'b0, i[2:0] ^ 3'b101, i[3:0]}, 0, "R5_ignored");
    // R6: mode word dropped
    drive(1, 8'hFF, 0, "R6_mode_word");
    drive(1, 8'h80, 0, "R6_mode_word");
    // R7: valid low with command-like data
    drive(0, 8'h0F, 0, "R7_idle");
    drive(0, 8'h01, 0, "R7_idle");
    // R9: basic mode, mask positions go to the latch
    drive(1, 8'h09, 0, "R9_basic_pos4");
    drive(1, 8'h05, 0, "R9_basic_pos2");
    // R8: handshake modes route to masks
    @(negedge clk); grp_a_mode = 2'd1; grp_b_mode = 1'b1;
    drive(1, 8'h09, 0, "R8_mask_pos4_set");
    drive(1, 8'h0D, 0, "R8_mask_pos6_set");
    drive(1, 8'h05, 0, "R8_mask_pos2_set");
    drive(1, 8'h08, 0, "R8_mask_pos4_clr");
    drive(1, 8'h07, 0, "R8_other_bit_latch");
    // R10: mode change clears, beats a same-cycle command
    drive(1, 8'h0B, 1, "R10_mode_chg_priority");
    drive(1, 8'h0D, 0, "R8_mask_after_clear");
    @(negedge clk); grp_a_mode = 2'd2; grp_b_mode = 1'b0;
    drive(1, 8'h05, 0, "R9_grp_b_basic");
    drive(1, 8'h09, 0, "R8_grp_a_mode2");
    drive(0, 8'h00, 1, "R10_mode_chg");
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule